// File: doc/BRIEF.md
# MMU Control Register File

This block holds the control, context and fault registers of a paged memory management unit, reached by a host through an alternate address space. It also decodes the flush commands issued through the same space. A host read or write carries a full 32-bit address, and the register index comes from a 5-bit field of that address. Some registers have side effects. Reading the fault status through its primary index clears it. Two alias indices read or load the fault registers without side effects. The top byte of the control register is fixed.

The block drives two one-cycle pulses toward the TLB. A full-flush pulse is raised when a control write changes a translation mode bit, or when a flush command of a coarse level arrives. A page-flush pulse, with its page number, is raised for a single-page flush command. A table walker loads both fault registers in one cycle through a capture strobe, and the capture has priority over any host access in the same cycle.

Top module: `mmu_regfile`

## Requirements
- R1: After reset the control register reads `{CTRL_ID, 24'h0}` (default 32'h4100_0000), every other register reads zero, and `flush_all`, `flush_page` and `reg_rdata` are zero.
- R2: The register index is `reg_addr[12:8]`, and all other address bits are ignored. `reg_rdata` takes the addressed value on the clock edge that samples `reg_rd` and holds it until the next read. Index 1 is a 32-bit table pointer. Index 2 is the context, CTX_W bits wide (default 8) and zero-extended on read. Indices without a register read zero.
- R3: A read of index 3 returns the fault status, and the fault status becomes zero on the same edge.
- R4: A read of index 0x13 returns the fault status and leaves it unchanged. Indices 0x14 and 4 both return the fault address.
- R5: A write to index 0x13 loads the fault status, and a write to index 0x14 loads the fault address. Writes to indices 3 and 4 change nothing.
- R6: A write to index 0 (control) updates bits 23:0 only. Bits 31:24 keep `CTRL_ID`.
- R7: `flush_all` pulses for one cycle, on the edge after a control write, exactly when the write changes bit 0 (enable), bit 1 (no-fault) or bit 14 (boot mode). A control write that changes only other bits raises no pulse.
- R8: A flush command with level `flush_addr[11:8] == 0` raises `flush_page` for one cycle on the next edge, with `flush_page_addr = flush_addr[31:12]`, and `flush_all` stays low.
- R9: A flush command with level 1 to 4 raises a one-cycle `flush_all`. Levels 5 to 15 raise no pulse.
- R10: `cap_valid` loads `cap_status` into the fault status and `cap_addr` into the fault address on one edge. In a cycle with a host write or a clearing read of those registers, the captured values win. A read in that cycle still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Host register read strobe |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 32 | Host access address, index in bits 12:8 |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered read data |
| flush_wr | input | 1 | Flush command strobe |
| flush_addr | input | 32 | Flush command address, level in bits 11:8, page in 31:12 |
| cap_valid | input | 1 | Fault capture strobe from the walker |
| cap_status | input | 32 | Captured fault status |
| cap_addr | input | 32 | Captured fault address |
| flush_all | output | 1 | One-cycle full TLB flush request |
| flush_page | output | 1 | One-cycle single-page flush request |
| flush_page_addr | output | 20 | Page number for the page flush |

## Verification
The assertions assume that the host never raises `reg_rd` and `reg_wr` in the same cycle. One assertion checks this assumption, and the bench's single stimulus task never issues both. The fault-register properties rely on a capture strobe taking priority, so they are qualified by `cap_valid` low. The bench drives deliberate collisions only between capture and one host access, and it checks their outcome through later reads. All inputs are driven at the falling edge, so each strobe is seen by exactly one rising edge.

// File: rtl/mmu_regfile.sv
module mmu_regfile #(
  parameter int          CTX_W     = 8,
  parameter logic [7:0]  CTRL_ID   = 8'h41,
  parameter logic [23:0] MODE_MASK = 24'h00_4003,
  parameter int          MAX_LVL   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [31:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        flush_wr,
  input  logic [31:0] flush_addr,
  input  logic        cap_valid,
  input  logic [31:0] cap_status,
  input  logic [31:0] cap_addr,
  output logic        flush_all,
  output logic        flush_page,
  output logic [19:0] flush_page_addr
);

  localparam logic [4:0] IX_CTRL = 5'h00, IX_CTP = 5'h01, IX_CTX = 5'h02,
                         IX_FST  = 5'h03, IX_FAD = 5'h04,
                         IX_FST_ALIAS = 5'h13, IX_FAD_ALIAS = 5'h14;

  logic [23:0]      ctrl_q;
  logic [31:0]      ctp_q, fst_q, fad_q, rd_mux;
  logic [CTX_W-1:0] ctx_q;

  wire [4:0] idx     = reg_addr[12:8];
  wire [3:0] lvl     = flush_addr[11:8];
  wire       ctrl_we = reg_wr && idx == IX_CTRL;
  wire       mode_ch = ctrl_we && (((ctrl_q ^ reg_wdata[23:0]) & MODE_MASK) != 24'h0);
  wire       cmd_pg  = flush_wr && lvl == 4'd0;
  wire       cmd_all = flush_wr && lvl != 4'd0 && 32'(lvl) <= MAX_LVL;

  logic unused_ok;
  assign unused_ok = ^{reg_addr[31:13], reg_addr[7:0], flush_addr[7:0]};

  always_comb begin
    case (idx)
      IX_CTRL:                rd_mux = {CTRL_ID, ctrl_q};
      IX_CTP:                 rd_mux = ctp_q;
      IX_CTX:                 rd_mux = 32'(ctx_q);
      IX_FST, IX_FST_ALIAS:   rd_mux = fst_q;
      IX_FAD, IX_FAD_ALIAS:   rd_mux = fad_q;
      default:                rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; ctp_q <= '0; ctx_q <= '0; fst_q <= '0; fad_q <= '0;
      reg_rdata <= '0; flush_all <= 1'b0; flush_page <= 1'b0; flush_page_addr <= '0;
    end else begin
      flush_all  <= mode_ch || cmd_all;
      flush_page <= cmd_pg;
      if (cmd_pg) flush_page_addr <= flush_addr[31:12];
      if (reg_rd) begin
        reg_rdata <= rd_mux;
        if (idx == IX_FST) fst_q <= '0;
      end
      if (reg_wr) begin
        case (idx)
          IX_CTRL:      ctrl_q <= reg_wdata[23:0];
          IX_CTP:       ctp_q  <= reg_wdata;
          IX_CTX:       ctx_q  <= reg_wdata[CTX_W-1:0];
          IX_FST_ALIAS: fst_q  <= reg_wdata;
          IX_FAD_ALIAS: fad_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (cap_valid) begin
        fst_q <= cap_status;
        fad_q <= cap_addr;
      end
    end
  end

  assert_no_rdwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  assert_fst_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && idx == IX_FST && !cap_valid) |=> fst_q == 32'h0);

  assert_alias_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && idx == IX_FST_ALIAS && !cap_valid) |=> $stable(fst_q));

  assert_direct_wr_ign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (idx == IX_FST || idx == IX_FAD) && !cap_valid) |=> ($stable(fst_q) && $stable(fad_q)));

  assert_all_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> ($past(reg_wr && idx == IX_CTRL) || $past(flush_wr)));

  assert_page_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_page |-> $past(flush_wr && flush_addr[11:8] == 4'd0));

  assert_page_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_page && flush_all && !$past(reg_wr)));

  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> (fst_q == $past(cap_status) && fad_q == $past(cap_addr)));

endmodule

// File: tb/mmu_regfile_tb.sv
module mmu_regfile_tb;
  logic clk = 0, rst_n = 0;
  logic reg_rd = 0, reg_wr = 0, flush_wr = 0, cap_valid = 0;
  logic [31:0] reg_addr = 0, reg_wdata = 0, flush_addr = 0, cap_status = 0, cap_addr = 0;
  logic [31:0] reg_rdata;
  logic flush_all, flush_page;
  logic [19:0] flush_page_addr;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_last = 0;

  always #2 clk = ~clk;

  mmu_regfile u_dut (.clk, .rst_n, .reg_rd, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .flush_wr, .flush_addr, .cap_valid, .cap_status, .cap_addr,
    .flush_all, .flush_page, .flush_page_addr);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_last <= reg_rd;
  always @(negedge clk) if (rd_last) begin
    if (exp_q.size() == 0) chk("R2 unexpected read", reg_rdata, 32'hx);
    else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
  end

  task automatic step(logic rd, logic wr, logic [31:0] a, logic [31:0] d,
                      logic fl, logic [31:0] fa, logic cv, logic [31:0] cs, logic [31:0] ca);
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    flush_wr = fl; flush_addr = fa; cap_valid = cv; cap_status = cs; cap_addr = ca;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; flush_wr = 0; cap_valid = 0;
  endtask

  task automatic rd(logic [4:0] ix, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    step(1, 0, {19'h0, ix, 8'h0}, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [4:0] ix, logic [31:0] d);
    step(0, 1, {19'h0, ix, 8'h0}, d, 0, 0, 0, 0, 0);
  endtask

  task automatic flush(logic [31:0] fa, logic e_all, logic e_pg, string tag);
    step(0, 0, 0, 0, 1, fa, 0, 0, 0);
    chk({tag, " all"}, 32'(flush_all), 32'(e_all));
    chk({tag, " page"}, 32'(flush_page), 32'(e_pg));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 flush_all", 32'(flush_all), 0);
    chk("R1 flush_page", 32'(flush_page), 0);
    rst_n = 1;
    rd(0, 32'h4100_0000, "R1 ctrl reset");
    rd(3, 0, "R1 fault status reset");
    rd(1, 0, "R1 table ptr reset");
    // R6: only low 24 bits, non-mode bit -> no flush (R7)
    wr(0, 32'hFF00_0100);
    chk("R7 non-mode no flush", 32'(flush_all), 0);
    rd(0, 32'h4100_0100, "R6 id kept");
    wr(0, 32'h0000_0101);
    chk("R7 enable change flush", 32'(flush_all), 1);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(flush_all), 0);
    wr(0, 32'h0000_0101);
    chk("R7 same value no flush", 32'(flush_all), 0);
    wr(0, 32'h0000_4101);
    chk("R7 boot bit flush", 32'(flush_all), 1);
    wr(0, 32'h0000_4103);
    chk("R7 no-fault bit flush", 32'(flush_all), 1);
    // R2
    wr(1, 32'hDEAD_BEEF);
    wr(2, 32'h0000_1234);
    rd(1, 32'hDEAD_BEEF, "R2 table ptr");
    rd(2, 32'h0000_0034, "R2 context width");
    rd(7, 0, "R2 unmapped index");
    exp_q.push_back(32'hDEAD_BEEF); tag_q.push_back("R2 other address bits ignored");
    step(1, 0, 32'hFFFF_E1FF, 0, 0, 0, 0, 0, 0);
    // R5
    wr(3, 32'h55); wr(4, 32'h66);
    rd(5'h13, 0, "R5 direct status write ignored");
    rd(5'h14, 0, "R5 direct address write ignored");
    wr(5'h13, 32'hAA); wr(5'h14, 32'h1000);
    rd(5'h13, 32'hAA, "R5 alias status write");
    rd(5'h13, 32'hAA, "R4 alias read keeps status");
    rd(5'h14, 32'h1000, "R4 alias address read");
    rd(4, 32'h1000, "R4 direct address read");
    rd(3, 32'hAA, "R3 read returns status");
    rd(3, 0, "R3 status cleared");
    // R10
    step(0, 0, 0, 0, 0, 0, 1, 32'h77, 32'h2000);
    rd(5'h13, 32'h77, "R10 captured status");
    rd(5'h14, 32'h2000, "R10 captured address");
    step(0, 1, {19'h0, 5'h13, 8'h0}, 32'h11, 0, 0, 1, 32'h99, 32'h3000);
    rd(5'h13, 32'h99, "R10 capture beats write");
    exp_q.push_back(32'h99); tag_q.push_back("R10 read during capture gets old");
    step(1, 0, {19'h0, 5'h03, 8'h0}, 0, 0, 0, 1, 32'h66, 32'h4000);
    rd(5'h13, 32'h66, "R10 capture beats clear");
    rd(5'h14, 32'h4000, "R10 capture address");
    // R8, R9
    flush(32'hABCD_E0FF, 0, 1, "R8 level0");
    chk("R8 page addr", 32'(flush_page_addr), 32'hABCDE);
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(flush_page), 0);
    for (int l = 1; l <= 4; l++) flush({20'h12345, 4'(l), 8'h0}, 1, 0, "R9 coarse level");
    flush(32'h0000_0500, 0, 0, "R9 level5");
    flush(32'h0000_0F00, 0, 0, "R9 level15");
    chk("R8 page addr held", 32'(flush_page_addr), 32'hABCDE);
    repeat (2) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule